// File: doc/BRIEF.md
# Dithered Duty-Cycle Stereo Audio Output

This block plays signed 16-bit stereo audio from a circular sample memory out of two 1-bit pins. It holds a byte read index into that memory. Once per sample period it fetches a pair of words, left first and then right. It tells the producer how far playback has advanced, so that the producer can refill whichever half of the buffer has been consumed.

Each held sample is offset to unsigned, scaled and biased into a 32-bit level. A per-channel pseudo-random term, taken from a 32-bit shift register and arithmetically shifted right by a programmable amount, is added to that level. The sum becomes the increment of a 32-bit phase accumulator. The accumulator's carry is the output pin, so the pin's long-run density of ones tracks the level. The dither term is refreshed on its own fast tick, independent of the sample tick. An external low-pass filter turns the pin into audio.

Top module: `stereo_dither_dac`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the read index and read_pos to 0, both accumulators and both pins to 0, both shift registers to 1, both held samples to 0, and both increments to 0x8000_0000.
- R2: The first fetch comes in the cycle FETCH_DIV-1 after reset, and fetches then repeat every FETCH_DIV cycles. In the cycle of a fetch, rd_addr equals the read index and the left word is captured. In the cycle that follows, rd_addr equals the read index plus 2 and the right word is captured. At all other times rd_addr equals the read index. rd_data must reflect rd_addr within the same cycle.
- R3: After the right word is captured, read_pos is set to the read index plus 4 without wrapping, so it can reach 2^IDX_W. The read index becomes that value modulo 2^IDX_W.
- R4: A held sample s maps to a level of (((s + 0x8000) mod 2^16) << 13) * 7 + 0x1000_0000, taken modulo 2^32.
- R5: On each dither tick, each shift register moves one place toward the MSB. Its new LSB is the parity of (state AND taps), with left taps 0xA400_0080 and right taps 0x80A0_1000.
- R6: The dither term is the new shift-register state, read as signed and arithmetically shifted right by dither_shift. A dither_shift below 2 acts as 2.
- R7: A dither tick comes every DITHER_DIV cycles, starting at cycle DITHER_DIV-1 after reset. On a dither tick, the increment becomes level(held sample) + dither term modulo 2^32. Between ticks the increment is held, and memory contents read at other times have no effect.
- R8: On every clock, each accumulator adds its increment modulo 2^32, and the pin takes the carry out of that addition.
- R9: When the buffer holds zeros and dither_shift is 31, each pin is high for close to half of all cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dither_shift | input | 5 | Arithmetic right shift applied to the dither term (2..31) |
| rd_addr | output | IDX_W | Byte address of the sample word being read |
| rd_data | input | 16 | Signed sample word at rd_addr, available in the same cycle |
| read_pos | output | IDX_W+1 | Unwrapped read index after the latest fetch |
| pin_l | output | 1 | Left channel 1-bit output |
| pin_r | output | 1 | Right channel 1-bit output |

## Verification
A wrong index or fetch phase shows at rd_addr within the same cycle. It shows at read_pos one cycle after the pair is fetched. A corrupted level, shift-register state or shift amount reaches the increment at the next dither tick. From there it changes the carry pattern within a few cycles, because the pins are compared against an independent cycle-level model on every clock. A stale increment that should have been held, or a sample taken at the wrong moment, breaks that same pin-by-pin agreement while the memory is being rewritten between fetches.

// File: rtl/stereo_dither_dac.sv
module stereo_dither_dac #(
  parameter int FETCH_DIV = 1812,
  parameter int DITHER_DIV = 80,
  parameter int IDX_W = 11,
  parameter logic [31:0] TAPS_L = 32'hA400_0080,
  parameter logic [31:0] TAPS_R = 32'h80A0_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       dither_shift,
  output logic [IDX_W-1:0] rd_addr,
  input  logic [15:0]      rd_data,
  output logic [IDX_W:0]   read_pos,
  output logic             pin_l,
  output logic             pin_r
);
  localparam int FW = $clog2(FETCH_DIV);
  localparam int DW = $clog2(DITHER_DIV);
  localparam logic [31:0] MID = 32'h8000_0000;

  function automatic logic [31:0] level(input logic [15:0] s);
    logic [31:0] u;
    u = 32'({~s[15], s[14:0]}) << 13;
    return (u << 2) + (u << 1) + u + 32'h1000_0000;
  endfunction

  logic [FW-1:0] fcnt;
  logic [DW-1:0] dcnt;
  logic ph2;
  logic [IDX_W-1:0] idx;
  logic [15:0] smp_l, smp_r;
  logic [31:0] lfsr_l, lfsr_r, inc_l, inc_r, acc_l, acc_r;

  wire ftick = fcnt == FW'(FETCH_DIV - 1);
  wire dtick = dcnt == DW'(DITHER_DIV - 1);
  wire [4:0] sh = (dither_shift < 5'd2) ? 5'd2 : dither_shift;
  wire [31:0] nl = {lfsr_l[30:0], ^(lfsr_l & TAPS_L)};
  wire [31:0] nr = {lfsr_r[30:0], ^(lfsr_r & TAPS_R)};
  wire [31:0] dl = 32'($signed(nl) >>> sh);
  wire [31:0] dr = 32'($signed(nr) >>> sh);

  assign rd_addr = ph2 ? idx + IDX_W'(2) : idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt <= '0;
      dcnt <= '0;
      ph2 <= 1'b0;
      idx <= '0;
      read_pos <= '0;
      smp_l <= '0;
      smp_r <= '0;
      lfsr_l <= 32'd1;
      lfsr_r <= 32'd1;
      inc_l <= MID;
      inc_r <= MID;
      acc_l <= '0;
      acc_r <= '0;
      pin_l <= 1'b0;
      pin_r <= 1'b0;
    end else begin
      fcnt <= ftick ? '0 : fcnt + FW'(1);
      dcnt <= dtick ? '0 : dcnt + DW'(1);
      if (ftick) begin
        smp_l <= rd_data;
        ph2 <= 1'b1;
      end
      if (ph2) begin
        smp_r <= rd_data;
        ph2 <= 1'b0;
        idx <= idx + IDX_W'(4);
        read_pos <= {1'b0, idx} + (IDX_W+1)'(4);
      end
      if (dtick) begin
        lfsr_l <= nl;
        lfsr_r <= nr;
        inc_l <= level(smp_l) + dl;
        inc_r <= level(smp_r) + dr;
      end
      {pin_l, acc_l} <= {1'b0, acc_l} + {1'b0, inc_l};
      {pin_r, acc_r} <= {1'b0, acc_r} + {1'b0, inc_r};
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (read_pos == '0 && rd_addr == '0 && !pin_l && !pin_r));
  a_r3_pos_matches_addr: assert property (@(posedge clk) disable iff (rst)
    ph2 |=> rd_addr == read_pos[IDX_W-1:0]);
  a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
    lfsr_l != '0 && lfsr_r != '0);
  a_r7_inc_held: assert property (@(posedge clk) disable iff (rst)
    !dtick |=> ($stable(inc_l) && $stable(inc_r)));
  a_r2_samples_held: assert property (@(posedge clk) disable iff (rst)
    (!ftick && !ph2) |=> ($stable(smp_l) && $stable(smp_r)));
endmodule

// File: tb/stereo_dither_dac_bench.sv
module stereo_dither_dac_bench;
  localparam int FD = 23;
  localparam int DD = 5;
  localparam int IW = 5;
  localparam int NW = 1 << (IW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] dither_shift = 5'd31;
  logic [IW-1:0] rd_addr;
  logic [15:0] rd_data;
  logic [IW:0] read_pos;
  logic pin_l, pin_r;
  logic [15:0] mem [NW];

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign rd_data = mem[rd_addr[IW-1:1]];

  stereo_dither_dac #(.FETCH_DIV(FD), .DITHER_DIV(DD), .IDX_W(IW)) u_stereo_dither_dac (
    .clk(clk), .rst(rst), .dither_shift(dither_shift), .rd_addr(rd_addr),
    .rd_data(rd_data), .read_pos(read_pos), .pin_l(pin_l), .pin_r(pin_r));

  int m_fc, m_dc, m_ph2;
  logic [IW-1:0] m_idx;
  logic [IW:0] m_pos;
  logic [15:0] m_sl, m_sr;
  logic [31:0] m_ll, m_lr, m_il, m_ir;
  logic [32:0] m_al, m_ar;

  function automatic logic [31:0] lvl(input logic [15:0] s);
    logic [31:0] u;
    u = 32'(16'(s + 16'h8000));
    return 32'((u << 13) * 7 + 32'h1000_0000);
  endfunction

  function automatic logic [31:0] stepl(input logic [31:0] st, input logic [31:0] taps);
    return {st[30:0], ^(st & taps)};
  endfunction

  function automatic logic [31:0] dith(input logic [31:0] st, input logic [4:0] sh);
    int k;
    k = (sh < 2) ? 2 : int'(sh);
    return 32'($signed(st) >>> k);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic [31:0] nl, nr;
    logic [IW-1:0] ea;
    @(posedge clk);
    if (rst) begin
      m_fc = 0; m_dc = 0; m_ph2 = 0; m_idx = '0; m_pos = '0;
      m_sl = '0; m_sr = '0; m_ll = 1; m_lr = 1;
      m_il = 32'h8000_0000; m_ir = 32'h8000_0000; m_al = '0; m_ar = '0;
    end else begin
      m_al = {1'b0, m_al[31:0]} + {1'b0, m_il};
      m_ar = {1'b0, m_ar[31:0]} + {1'b0, m_ir};
      if (m_dc == DD - 1) begin
        nl = stepl(m_ll, 32'hA400_0080);
        nr = stepl(m_lr, 32'h80A0_1000);
        m_ll = nl; m_lr = nr;
        m_il = lvl(m_sl) + dith(nl, dither_shift);
        m_ir = lvl(m_sr) + dith(nr, dither_shift);
      end
      if (m_ph2 == 1) begin
        m_sr = mem[4'(m_idx[IW-1:1] + 1)];
        m_pos = {1'b0, m_idx} + 4;
        m_idx = m_idx + 4;
        m_ph2 = 0;
      end else if (m_fc == FD - 1) begin
        m_sl = mem[m_idx[IW-1:1]];
        m_ph2 = 1;
      end
      m_fc = (m_fc == FD - 1) ? 0 : m_fc + 1;
      m_dc = (m_dc == DD - 1) ? 0 : m_dc + 1;
    end
    @(negedge clk);
    ea = m_ph2 ? m_idx + 2 : m_idx;
    check("R2", "rd_addr", 32'(rd_addr), 32'(ea));
    check("R3", "read_pos", 32'(read_pos), 32'(m_pos));
    check(req, "pin_l", 32'(pin_l), 32'(rst ? 1'b0 : m_al[32]));
    check(req, "pin_r", 32'(pin_r), 32'(rst ? 1'b0 : m_ar[32]));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int ones_l, ones_r;
    for (int i = 0; i < NW; i++) mem[i] = '0;
    rst = 1'b1;
    dither_shift = 5'd31;
    @(negedge clk);
    step("R1");
    step("R1");
    rst = 1'b0;
    check("R1", "read_pos after reset", 32'(read_pos), 0);
    check("R1", "rd_addr after reset", 32'(rd_addr), 0);
    check("R1", "pins after reset", 32'({pin_l, pin_r}), 0);
    ones_l = 0; ones_r = 0;
    for (int c = 0; c < 400; c++) begin
      step("R9");
      ones_l += pin_l; ones_r += pin_r;
    end
    check("R9", "left duty near half", 32'(ones_l >= 190 && ones_l <= 210), 1);
    check("R9", "right duty near half", 32'(ones_r >= 190 && ones_r <= 210), 1);

    for (int i = 0; i < NW; i++) mem[i] = 16'(i * 16'h1357 + 16'h0101);
    mem[0] = 16'h7FFF; mem[1] = 16'h8000; mem[2] = 16'hFFFF; mem[3] = 16'h0000;
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    dither_shift = 5'd31;
    for (int c = 0; c < 700; c++) step("R4");
    dither_shift = 5'd3;
    for (int c = 0; c < 700; c++) step("R5");
    dither_shift = 5'd0;
    for (int c = 0; c < 400; c++) step("R6");
    dither_shift = 5'd1;
    for (int c = 0; c < 400; c++) step("R6");
    dither_shift = 5'd9;
    for (int c = 0; c < 900; c++) begin
      mem[c % NW] = 16'(c * 16'h2F1D);
      step("R7");
    end
    dither_shift = 5'd17;
    for (int c = 0; c < 600; c++) step("R8");
    check("R3", "index wrapped through buffer", 32'(read_pos <= (1 << IW)), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule